// File: doc/BRIEF.md
# DMA Channel Register File

This block is the host-side register file of a four-channel DMA controller. A host reaches it through an 8-bit data bus and a 4-bit register offset. Each channel keeps a 16-bit transfer address and a 16-bit transfer count. The count holds the number of transfers minus one. Both sit behind one byte-pointer flip-flop that all channels share. The pointer picks the low or the high byte of every access, and it flips after each such access.

Alongside the per-channel words, the block holds:
- a mask bit for each channel;
- a mode field for each channel;
- a software request bit for each channel;
- a command byte;
- terminal-count flags that the host reads back as status.

A transfer engine next to the block rewrites the current address and count copies while it runs, and it flags terminal count. The base copies, which the host loaded, stay as they were for auto-initialize. Writes that carry a channel number inside the data byte let the host change one channel's mask, mode or request without a read-modify-write.

Top module: `dma_regfile`

## Requirements
- R1: After an active-low synchronous reset, all four mask bits are 1. The byte pointer selects the low byte. All address, count, mode, command, request and terminal-count state is zero, so a status read returns 0x00.
- R2: Offset 2n addresses channel n's address word and offset 2n+1 its count word, for n = 0..3. A write with the pointer at low stores data into bits [7:0] of both the base and current copies, and a write with the pointer at high stores into bits [15:8]. A read returns the selected byte of the current copy on bus_rdata in the same cycle.
- R3: Every read or write to offsets 0x0–0x7 flips the one byte pointer. The pointer is shared, so a low-byte write to one register followed by a write to another register lands in the second register's high byte.
- R4: A write of any value to offset 0xC returns the pointer to the low byte.
- R5: A write to offset 0xA sets the mask of channel data[1:0] to data[2]. The other masks are kept.
- R6: A write to offset 0xB stores data[7:2] as the mode field of channel data[1:0], exported on ch_mode[6n+5:6n]. For example, 0x44 is I/O-to-memory with increment, 0x48 is memory-to-I/O, 0xC0 is cascade, and 0x10 adds auto-initialize.
- R7: A write to offset 0x8 loads the command byte, exported on cmd_reg.
- R8: A read of offset 0x8 returns {request[3:0], terminal_count[3:0]}. A pulse on eng_tc sets terminal_count[eng_ch]. A status read clears the terminal-count bits, but a flag raised in the same cycle survives.
- R9: A write to offset 0xD sets all masks and selects the low byte. It also clears the command, request and terminal-count state. Address, count and mode are kept. A read of 0xD, like any other offset above 0x8, returns 0x00.
- R10: A write to offset 0xE clears all four masks. A write to offset 0xF loads the masks from data[3:0].
- R11: eng_upd loads eng_addr and eng_cnt into the current copies of channel eng_ch and leaves the base copies alone. When a host write to the same word lands in the same cycle, the host byte wins.
- R12: A write to offset 0x9 sets the request bit of channel data[1:0] to data[2]. The request bits are exported on ch_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per byte |
| bus_rd | input | 1 | Host read strobe, one cycle per byte |
| bus_off | input | 4 | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational |
| eng_upd | input | 1 | Engine loads current address and count |
| eng_ch | input | 2 | Channel addressed by the engine |
| eng_addr | input | 16 | New current address |
| eng_cnt | input | 16 | New current count |
| eng_tc | input | 1 | Terminal count pulse for eng_ch |
| ch_addr | output | 64 | Current addresses, channel n at [16n+15:16n] |
| ch_cnt | output | 64 | Current counts, same packing |
| ch_base_addr | output | 64 | Base addresses |
| ch_base_cnt | output | 64 | Base counts |
| ch_mode | output | 24 | Mode fields, channel n at [6n+5:6n] |
| ch_mask | output | 4 | Channel masks |
| ch_req | output | 4 | Software request bits |
| cmd_reg | output | 8 | Command byte |

## Verification
The assertions check on every cycle that each access to an address or count word flips the byte pointer and that the clear-pointer, master-clear, clear-all-masks and single-mask writes reach their stated state one cycle later. They also check that command writes take effect, that a status read with no new terminal count leaves the flags empty, and that engine updates never disturb the base copies. Only the bench's scenarios show which byte lands where across a sequence of accesses. That includes the shared pointer carrying over between channels and host-over-engine priority on the same word. The scenarios also show the read value of a completed count (0xFFFF), that a terminal-count flag survives a simultaneous status read, and that random interleavings keep every exported register in step with an independent model.

// File: rtl/dma_regfile.sv
module dma_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_off,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        eng_upd,
  input  logic [1:0]  eng_ch,
  input  logic [15:0] eng_addr,
  input  logic [15:0] eng_cnt,
  input  logic        eng_tc,
  output logic [63:0] ch_addr,
  output logic [63:0] ch_cnt,
  output logic [63:0] ch_base_addr,
  output logic [63:0] ch_base_cnt,
  output logic [23:0] ch_mode,
  output logic [3:0]  ch_mask,
  output logic [3:0]  ch_req,
  output logic [7:0]  cmd_reg
);
  localparam logic [3:0] OFF_CMD  = 4'h8;
  localparam logic [3:0] OFF_REQ  = 4'h9;
  localparam logic [3:0] OFF_MSK1 = 4'hA;
  localparam logic [3:0] OFF_MODE = 4'hB;
  localparam logic [3:0] OFF_PCLR = 4'hC;
  localparam logic [3:0] OFF_MCLR = 4'hD;
  localparam logic [3:0] OFF_MOFF = 4'hE;
  localparam logic [3:0] OFF_MALL = 4'hF;

  logic       ptr;
  logic [3:0] tc;
  logic       rd, word_acc, mclr, stat_rd;
  logic [1:0] sel;
  logic [3:0] tc_set;
  logic [15:0] rd_word;

  assign rd       = bus_rd & ~bus_wr;
  assign word_acc = ~bus_off[3];
  assign sel      = bus_off[2:1];
  assign mclr     = bus_wr && bus_off == OFF_MCLR;
  assign stat_rd  = rd && bus_off == OFF_CMD;
  assign tc_set   = eng_tc ? (4'b0001 << eng_ch) : 4'b0000;

  for (genvar i = 0; i < 4; i++) begin : g_ch
    logic [15:0] ba, ca, bc, cc;
    logic [5:0]  md;
    logic        hit_a, hit_c, eng_hit;

    assign hit_a   = bus_wr && word_acc && sel == 2'(i) && !bus_off[0];
    assign hit_c   = bus_wr && word_acc && sel == 2'(i) &&  bus_off[0];
    assign eng_hit = eng_upd && eng_ch == 2'(i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ba <= '0; ca <= '0; bc <= '0; cc <= '0; md <= '0;
      end else begin
        if (eng_hit) begin
          ca <= eng_addr;
          cc <= eng_cnt;
        end
        if (hit_a) begin
          if (ptr) begin
            ba[15:8] <= bus_wdata;
            ca[15:8] <= bus_wdata;
          end else begin
            ba[7:0] <= bus_wdata;
            ca[7:0] <= bus_wdata;
          end
        end
        if (hit_c) begin
          if (ptr) begin
            bc[15:8] <= bus_wdata;
            cc[15:8] <= bus_wdata;
          end else begin
            bc[7:0] <= bus_wdata;
            cc[7:0] <= bus_wdata;
          end
        end
        if (bus_wr && bus_off == OFF_MODE && bus_wdata[1:0] == 2'(i))
          md <= bus_wdata[7:2];
      end
    end

    assign ch_addr[16*i +: 16]      = ca;
    assign ch_cnt[16*i +: 16]       = cc;
    assign ch_base_addr[16*i +: 16] = ba;
    assign ch_base_cnt[16*i +: 16]  = bc;
    assign ch_mode[6*i +: 6]        = md;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= 1'b0;
    end else if (mclr || (bus_wr && bus_off == OFF_PCLR)) begin
      ptr <= 1'b0;
    end else if ((bus_wr || rd) && word_acc) begin
      ptr <= ~ptr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mclr) begin
      ch_mask <= 4'hF;
    end else if (bus_wr) begin
      case (bus_off)
        OFF_MSK1: ch_mask[bus_wdata[1:0]] <= bus_wdata[2];
        OFF_MOFF: ch_mask <= 4'h0;
        OFF_MALL: ch_mask <= bus_wdata[3:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mclr) begin
      cmd_reg <= '0;
      ch_req  <= '0;
    end else if (bus_wr) begin
      if (bus_off == OFF_CMD) cmd_reg <= bus_wdata;
      if (bus_off == OFF_REQ) ch_req[bus_wdata[1:0]] <= bus_wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tc <= '0;
    else        tc <= ((mclr || stat_rd) ? 4'h0 : tc) | tc_set;
  end

  assign rd_word = bus_off[0] ? ch_cnt[16*sel +: 16] : ch_addr[16*sel +: 16];

  always_comb begin
    if (word_acc)                bus_rdata = ptr ? rd_word[15:8] : rd_word[7:0];
    else if (bus_off == OFF_CMD) bus_rdata = {ch_req, tc};
    else                         bus_rdata = 8'h00;
  end
endmodule

module dma_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [3:0]  bus_off,
  input logic [7:0]  bus_wdata,
  input logic        eng_upd,
  input logic        eng_tc,
  input logic        ptr,
  input logic [3:0]  tc,
  input logic [3:0]  ch_mask,
  input logic [7:0]  cmd_reg,
  input logic [63:0] ch_base_addr,
  input logic [63:0] ch_base_cnt
);
  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !bus_off[3]) |=> ptr != $past(ptr)); // R3
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == 4'hC) |=> !ptr); // R4
  AST_MASK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == 4'hA) |=> ch_mask[$past(bus_wdata[1:0])] == $past(bus_wdata[2])); // R5
  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == 4'h8) |=> cmd_reg == $past(bus_wdata)); // R7
  AST_TC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_off == 4'h8 && !eng_tc) |=> tc == 4'h0); // R8
  AST_MASTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == 4'hD) |=> (ch_mask == 4'hF && cmd_reg == 8'h00 && !ptr)); // R9
  AST_MASK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == 4'hE) |=> ch_mask == 4'h0); // R10
  AST_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_upd && !(bus_wr && !bus_off[3])) |=> ($stable(ch_base_addr) && $stable(ch_base_cnt))); // R11
endmodule

bind dma_regfile dma_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_off(bus_off), .bus_wdata(bus_wdata), .eng_upd(eng_upd),
  .eng_tc(eng_tc), .ptr(ptr), .tc(tc), .ch_mask(ch_mask),
  .cmd_reg(cmd_reg), .ch_base_addr(ch_base_addr), .ch_base_cnt(ch_base_cnt)
);

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_off = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        eng_upd = 1'b0, eng_tc = 1'b0;
  logic [1:0]  eng_ch = '0;
  logic [15:0] eng_addr = '0, eng_cnt = '0;
  logic [63:0] ch_addr, ch_cnt, ch_base_addr, ch_base_cnt;
  logic [23:0] ch_mode;
  logic [3:0]  ch_mask, ch_req;
  logic [7:0]  cmd_reg;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_regfile dut_i (.*);

  logic [15:0] m_ba [4], m_ca [4], m_bc [4], m_cc [4];
  logic [5:0]  m_md [4];
  logic [3:0]  m_mask, m_req, m_tc;
  logic [7:0]  m_cmd;
  logic        m_ptr;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [3:0] off);
    logic [15:0] w;
    if (!off[3]) begin
      w = off[0] ? m_cc[off[2:1]] : m_ca[off[2:1]];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (off == 4'h8) return {m_req, m_tc};
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_ba[i] = '0; m_ca[i] = '0; m_bc[i] = '0; m_cc[i] = '0; m_md[i] = '0;
    end
    m_mask = 4'hF; m_req = '0; m_tc = '0; m_cmd = '0; m_ptr = 1'b0;
  endtask

  task automatic compare_all();
    logic [63:0] pa, pc, pba, pbc;
    logic [23:0] pm;
    for (int i = 0; i < 4; i++) begin
      pa[16*i +: 16] = m_ca[i]; pc[16*i +: 16] = m_cc[i];
      pba[16*i +: 16] = m_ba[i]; pbc[16*i +: 16] = m_bc[i];
      pm[6*i +: 6] = m_md[i];
    end
    check("R2/R11 current address", ch_addr, pa);
    check("R2/R11 current count", ch_cnt, pc);
    check("R2/R11 base address", ch_base_addr, pba);
    check("R2/R11 base count", ch_base_cnt, pbc);
    check("R6 mode fields", 64'(ch_mode), 64'(pm));
    check("R5/R9/R10 masks", 64'(ch_mask), 64'(m_mask));
    check("R12 request bits", 64'(ch_req), 64'(m_req));
    check("R7 command", 64'(cmd_reg), 64'(m_cmd));
  endtask

  task automatic cyc(bit wr, bit rd, logic [3:0] off, logic [7:0] d,
                     bit eu, logic [1:0] ec, logic [15:0] ea, logic [15:0] en, bit et);
    logic [7:0] got, want;
    logic [1:0] ch;
    bit rde, mclr;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_off = off; bus_wdata = d;
    eng_upd = eu; eng_ch = ec; eng_addr = ea; eng_cnt = en; eng_tc = et;
    #1;
    got = bus_rdata;
    want = exp_read(off);
    rde = rd && !wr;
    if (rde) check("R2/R3/R8 read data", 64'(got), 64'(want));
    @(posedge clk);
    #1;
    bus_wr = 0; bus_rd = 0; eng_upd = 0; eng_tc = 0;
    ch = off[2:1];
    mclr = wr && off == 4'hD;
    if (eu) begin m_ca[ec] = ea; m_cc[ec] = en; end
    if (wr && !off[3]) begin
      if (off[0]) begin
        if (m_ptr) begin m_bc[ch][15:8] = d; m_cc[ch][15:8] = d; end
        else       begin m_bc[ch][7:0]  = d; m_cc[ch][7:0]  = d; end
      end else begin
        if (m_ptr) begin m_ba[ch][15:8] = d; m_ca[ch][15:8] = d; end
        else       begin m_ba[ch][7:0]  = d; m_ca[ch][7:0]  = d; end
      end
    end
    if (wr && off == 4'hB) m_md[d[1:0]] = d[7:2];
    if (mclr || (wr && off == 4'hC)) m_ptr = 1'b0;
    else if ((wr || rde) && !off[3]) m_ptr = ~m_ptr;
    if (mclr) begin m_mask = 4'hF; m_cmd = '0; m_req = '0; end
    else if (wr) begin
      if (off == 4'hA) m_mask[d[1:0]] = d[2];
      if (off == 4'hE) m_mask = 4'h0;
      if (off == 4'hF) m_mask = d[3:0];
      if (off == 4'h8) m_cmd = d;
      if (off == 4'h9) m_req[d[1:0]] = d[2];
    end
    if (mclr || (rde && off == 4'h8)) m_tc = 4'h0;
    if (et) m_tc[ec] = 1'b1;
    compare_all();
  endtask

  task automatic wr8(logic [3:0] off, logic [7:0] d);
    cyc(1, 0, off, d, 0, 0, 0, 0, 0);
  endtask
  task automatic rd8(logic [3:0] off);
    cyc(0, 1, off, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0D1A));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    #1 compare_all();
    check("R1 pointer low after reset", 64'(exp_read(4'h0)), 64'h0);
    rd8(4'h8);
    // R2 two-byte load and readback
    wr8(4'h4, 8'h34); wr8(4'h4, 8'h12);
    check("R2 channel 2 address", 64'(ch_addr[47:32]), 64'h1234);
    rd8(4'h4); rd8(4'h4);
    // R3 shared pointer across registers
    wr8(4'h0, 8'hAA); wr8(4'h1, 8'hBB);
    check("R3 high byte on other register", 64'(ch_cnt[15:0]), 64'hBB00);
    // R4 clear pointer
    wr8(4'h6, 8'h11); wr8(4'hC, 8'h99); wr8(4'h6, 8'h22);
    check("R4 low byte after clear", 64'(ch_addr[63:48]), 64'h0022);
    wr8(4'hC, 8'h00);
    // R5 single mask, R10 all masks
    wr8(4'hE, 0); wr8(4'hA, 8'h06); wr8(4'hA, 8'h01); wr8(4'hF, 8'h09); wr8(4'hE, 8'h5A);
    // R6 modes
    wr8(4'hB, 8'h44 | 8'h1); wr8(4'hB, 8'h48 | 8'h2); wr8(4'hB, 8'hC3); wr8(4'hB, 8'h54);
    check("R6 cascade mode on channel 3", 64'(ch_mode[23:18]), 64'h30);
    // R7 command, R12 request
    wr8(4'h8, 8'hA5); wr8(4'h9, 8'h05); wr8(4'h9, 8'h06); wr8(4'h9, 8'h01);
    // R8 terminal count and status
    cyc(0, 0, 4'h0, 0, 1, 2'd1, 16'h8000, 16'hFFFF, 1);
    rd8(4'h8); rd8(4'h8);
    cyc(0, 1, 4'h8, 0, 0, 2'd3, 0, 0, 1);
    rd8(4'h8);
    // R11 count 0xFFFF after completed transfer reads back FF FF
    wr8(4'hC, 0); rd8(4'h3); rd8(4'h3);
    // R11 host write beats engine on same word
    wr8(4'hC, 0);
    cyc(1, 0, 4'h2, 8'h77, 1, 2'd1, 16'h4321, 16'h1111, 0);
    check("R11 host byte wins", 64'(ch_addr[31:16]), 64'h4377);
    // R9 master clear
    wr8(4'h8, 8'h3C); wr8(4'h0, 8'h01);
    cyc(0, 0, 4'h0, 0, 0, 2'd0, 0, 0, 1);
    wr8(4'hD, 8'h00);
    rd8(4'hD); rd8(4'h8); rd8(4'h0);
    // random mix
    for (int k = 0; k < 600; k++) begin
      bit w, r, eu, et;
      logic [3:0] o;
      w  = ($urandom % 3) != 0;
      r  = !w && ($urandom % 2);
      o  = 4'($urandom);
      if (o == 4'hD && ($urandom % 4) != 0) o = 4'hC;
      eu = ($urandom % 4) == 0;
      et = ($urandom % 6) == 0;
      cyc(w, r, o, 8'($urandom), eu, 2'($urandom), 16'($urandom), 16'($urandom), et);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule